// File: doc/BRIEF.md
# Asynchronous SCSI Byte Handshake Engine

This block moves one byte at a time between a SCSI target and its host over the asynchronous REQ/ACK handshake. A controller pulses `start` with `dir_rx` to pick the direction. To send a byte to the host, the engine drives the byte and its odd parity bit onto the data bus. After a programmable setup time it raises REQ and waits for the host to acknowledge, then releases the bus. To take a byte from the host, the engine raises REQ. It waits for ACK and lets the bus settle for a programmable hold time. It then captures the nine data lines and drops REQ.

All bus-side signals are active-high inside the block. Inverting them for the open-collector bus is left to the pad ring. The ACK input passes through a synchronizer. A latched assertion-edge flag also records it, so that a single-cycle ACK pulse during a send is never lost. The bus reset input ends any wait at once. Parity failures raise a flag that stays set until the controller starts the next byte.

Top module: `scsi_byte_hs`

## Requirements
- R1: While `rst_n` is low and after its release, `req_out`, `db_oe`, `done` and `par_err` are all 0.
- R2: On a send, `db_out` carries the write byte in bits 7:0 and its odd parity bit in bit 8, so that the nine bits hold an odd number of ones. `db_oe` rises on the clock edge that accepts `start`. `req_out` rises exactly SETUP_CYC cycles after `db_oe`, and `db_out` stays constant while `db_oe` is high.
- R3: On a send, `req_out` stays high until ACK is seen, either as a level or as a latched single-cycle pulse. `req_out` and `db_oe` then fall on the same clock edge.
- R4: On a send, `done` pulses for exactly one cycle, and only after ACK has returned inactive.
- R5: On a receive, `req_out` is high one cycle after `start`. It falls SYNC_STAGES+1+SAMPLE_CYC cycles after ACK goes active, and at that point `rd_byte` equals `db_in[7:0]`.
- R6: On a receive, `done` pulses for one cycle, and only after ACK has returned inactive.
- R7: A received word is a parity error when the nine bits of `db_in`, with parity in bit 8, hold an even number of ones. `par_err` is then set.
- R8: `par_err` holds its value until a `start` is accepted in idle, which clears it.
- R9: When `bus_rst` is high while the engine is busy, `req_out` and `db_oe` are low on the next cycle, `done` pulses and the engine returns to idle.
- R10: A `start` that arrives while a transfer is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| dir_rx | input | 1 | 1 = receive from host, 0 = send to host |
| wr_byte | input | 8 | Byte to send |
| rd_byte | output | 8 | Last received byte |
| done | output | 1 | One-cycle completion strobe |
| par_err | output | 1 | Sticky receive parity error |
| bus_rst | input | 1 | Bus reset flag, aborts any wait |
| ack_in | input | 1 | ACK from host, active-high, asynchronous |
| db_in | input | 9 | Bus data in, parity in bit 8 |
| db_out | output | 9 | Bus data out, parity in bit 8 |
| db_oe | output | 1 | Data bus drive enable |
| req_out | output | 1 | REQ to host, active-high |

## Verification
The bench counts the cycles between data enable and REQ on a send, and between ACK and the capture on a receive. An off-by-one counter or a missing synchronizer stage changes either count by a cycle. A send is acknowledged once with a held ACK and once with a one-cycle pulse, so a design that misses the pulse hangs with REQ high. ACK is held active for several cycles after REQ drops, which catches a design that reports completion before the host lets go. Further cases cover a bad parity word followed by a clean transfer to test stickiness and clearing, a bus reset in both directions, and a stray `start` during a receive that must not drive the bus.

// File: rtl/scsi_hs_pkg.sv
package scsi_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_SETUP,
    ST_TX_REQ,
    ST_TX_REL,
    ST_RX_REQ,
    ST_RX_HOLD,
    ST_RX_REL
  } hs_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BUS_W  = BYTE_W + 1;

endpackage

// File: rtl/hs_ack_sync.sv
module hs_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_raw,
  input  logic flag_clr,
  output logic ack_lvl,
  output logic ack_flag
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              flag_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= ack_raw;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], ack_raw};
      end
    end
  endgenerate

  assign ack_lvl = chain_q[STAGES-1];

  // Set wins over clear so an edge landing on the clear cycle is kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= ack_lvl;
      if (ack_lvl && !prev_q) flag_q <= 1'b1;
      else if (flag_clr)      flag_q <= 1'b0;
    end
  end

  assign ack_flag = flag_q;

endmodule

// File: rtl/hs_delay.sv
module hs_delay #(
  parameter int unsigned CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);

  localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)     cnt_d = '0;
    else if (!hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = run && (cnt_q == CW'(CYC - 1));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CYC));

endmodule

// File: rtl/hs_parity.sv
module hs_parity
  import scsi_hs_pkg::*;
(
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [BUS_W-1:0]  rx_word,
  output logic              tx_par,
  output logic              rx_bad
);

  // Odd parity: the bit makes the nine-bit word's ones count odd.
  assign tx_par = ~^tx_byte;
  assign rx_bad = ~^rx_word;

endmodule

// File: rtl/scsi_byte_hs.sv
module scsi_byte_hs
  import scsi_hs_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 25,
  parameter int unsigned SAMPLE_CYC  = 25,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dir_rx,
  input  logic [7:0] wr_byte,
  output logic [7:0] rd_byte,
  output logic       done,
  output logic       par_err,
  input  logic       bus_rst,
  input  logic       ack_in,
  input  logic [8:0] db_in,
  output logic [8:0] db_out,
  output logic       db_oe,
  output logic       req_out
);

  hs_state_e         st_q, st_d;
  logic              req_q, req_d;
  logic              oe_q, oe_d;
  logic [BUS_W-1:0]  dout_q, dout_d;
  logic [BYTE_W-1:0] rd_q, rd_d;
  logic              perr_q, perr_d;
  logic              done_q, done_d;
  logic              edge_clr;
  logic              ack_lvl, ack_flag;
  logic              setup_hit, sample_hit;
  logic              tx_par, rx_bad;

  hs_ack_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_raw (ack_in),
    .flag_clr(edge_clr),
    .ack_lvl (ack_lvl),
    .ack_flag(ack_flag)
  );

  hs_delay #(.CYC(SETUP_CYC)) u_setup (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_TX_SETUP),
    .hit  (setup_hit)
  );

  hs_delay #(.CYC(SAMPLE_CYC)) u_sample (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_RX_HOLD),
    .hit  (sample_hit)
  );

  hs_parity u_par (
    .tx_byte(wr_byte),
    .rx_word(db_in),
    .tx_par (tx_par),
    .rx_bad (rx_bad)
  );

  always_comb begin
    st_d     = st_q;
    req_d    = req_q;
    oe_d     = oe_q;
    dout_d   = dout_q;
    rd_d     = rd_q;
    perr_d   = perr_q;
    done_d   = 1'b0;
    edge_clr = 1'b0;
    if (st_q != ST_IDLE && bus_rst) begin
      st_d   = ST_IDLE;
      req_d  = 1'b0;
      oe_d   = 1'b0;
      dout_d = '0;
      done_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            perr_d = 1'b0;
            if (dir_rx) begin
              st_d  = ST_RX_REQ;
              req_d = 1'b1;
            end else begin
              st_d   = ST_TX_SETUP;
              oe_d   = 1'b1;
              dout_d = {tx_par, wr_byte};
            end
          end
        end
        ST_TX_SETUP: begin
          if (setup_hit) begin
            st_d     = ST_TX_REQ;
            req_d    = 1'b1;
            edge_clr = 1'b1;
          end
        end
        ST_TX_REQ: begin
          if (ack_flag || ack_lvl) begin
            st_d   = ST_TX_REL;
            req_d  = 1'b0;
            oe_d   = 1'b0;
            dout_d = '0;
          end
        end
        ST_TX_REL: begin
          if (!ack_lvl) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        ST_RX_REQ: begin
          if (ack_lvl) st_d = ST_RX_HOLD;
        end
        ST_RX_HOLD: begin
          if (sample_hit) begin
            st_d  = ST_RX_REL;
            rd_d  = db_in[BYTE_W-1:0];
            req_d = 1'b0;
            if (rx_bad) perr_d = 1'b1;
          end
        end
        ST_RX_REL: begin
          if (!ack_lvl) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      oe_q   <= 1'b0;
      dout_q <= '0;
      rd_q   <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      oe_q   <= oe_d;
      dout_q <= dout_d;
      rd_q   <= rd_d;
      perr_q <= perr_d;
      done_q <= done_d;
    end
  end

  assign req_out = req_q;
  assign db_oe   = oe_q;
  assign db_out  = dout_q;
  assign rd_byte = rd_q;
  assign par_err = perr_q;
  assign done    = done_q;

  p_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |=> (!db_oe || $stable(db_out)));

  p_tx_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_REL) |-> (!req_out && !db_oe));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_perr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !(start && st_q == ST_IDLE)) |=> par_err);

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && bus_rst) |=> (!req_out && !db_oe && done));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX_REQ && !ack_lvl && !bus_rst) |=> (st_q == ST_RX_REQ && !db_oe));

endmodule

// File: tb/tb_scsi_byte_hs.sv
module tb_scsi_byte_hs;

  localparam int SETUP  = 3;
  localparam int SAMPLE = 5;
  localparam int SYNC   = 2;
  localparam int TMO    = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       dir_rx = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic       done;
  logic       par_err;
  logic       bus_rst = 1'b0;
  logic       ack_in = 1'b0;
  logic [8:0] db_in = '0;
  logic [8:0] db_out;
  logic       db_oe;
  logic       req_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  scsi_byte_hs #(.SETUP_CYC(SETUP), .SAMPLE_CYC(SAMPLE), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rx(dir_rx), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .done(done), .par_err(par_err), .bus_rst(bus_rst),
    .ack_in(ack_in), .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .req_out(req_out)
  );

  // {rx, bad_parity, pulse_ack, byte}
  localparam logic [10:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b1, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h3C},
    {1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b0, 1'b0, 1'b1, 8'h81},
    {1'b1, 1'b0, 1'b0, 8'h01},
    {1'b0, 1'b0, 1'b0, 8'h7E},
    {1'b1, 1'b1, 1'b0, 8'h10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic rx, input logic [7:0] b);
    dir_rx = rx; wr_byte = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < TMO) begin @(negedge clk); n++; end
    check(req, done, 1'b1);
    @(negedge clk);
    check(req, done, 1'b0);
  endtask

  task automatic do_tx(input logic [7:0] b, input logic pulse);
    int n = 0;
    pulse_start(1'b0, b);
    check("R2", db_out, {~^b, b});
    while (!req_out && n < TMO) begin
      if (!db_oe) n = TMO;
      n++; @(negedge clk);
    end
    check("R2", n, SETUP);
    repeat (4) @(negedge clk);
    check("R3", req_out, 1'b1);
    ack_in = 1'b1;
    if (pulse) begin @(negedge clk); ack_in = 1'b0; end
    n = 0;
    while (req_out && n < TMO) begin @(negedge clk); n++; end
    check("R3", {req_out, db_oe}, 2'b00);
    if (!pulse) begin
      repeat (3) begin @(negedge clk); check("R4", done, 1'b0); end
      ack_in = 1'b0;
    end
    wait_done("R4");
  endtask

  task automatic do_rx(input logic [7:0] b, input logic badp);
    int n = 0;
    pulse_start(1'b1, b);
    check("R5", req_out, 1'b1);
    db_in = {badp ? ^b : ~^b, b};
    ack_in = 1'b1;
    while (req_out && n < TMO) begin @(negedge clk); n++; end
    check("R5", n, SYNC + 1 + SAMPLE);
    check("R5", rd_byte, b);
    check("R7", par_err, badp);
    repeat (3) begin @(negedge clk); check("R6", done, 1'b0); end
    ack_in = 1'b0;
    wait_done("R6");
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {req_out, db_oe, done, par_err}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {req_out, db_oe, done, par_err}, 4'b0000);

    for (int i = 0; i < 8; i++) begin
      if (VEC[i][10]) do_rx(VEC[i][7:0], VEC[i][9]);
      else            do_tx(VEC[i][7:0], VEC[i][8]);
    end

    // R8: sticky error survives idle, cleared by the next accepted start
    do_rx(8'h55, 1'b1);
    repeat (5) @(negedge clk);
    check("R8", par_err, 1'b1);
    pulse_start(1'b0, 8'h12);
    check("R8", par_err, 1'b0);
    repeat (SETUP + 1) @(negedge clk);
    ack_in = 1'b1;
    while (req_out) @(negedge clk);
    ack_in = 1'b0;
    wait_done("R8");

    // R9: bus reset while waiting for ACK on a send
    pulse_start(1'b0, 8'hC3);
    repeat (SETUP + 2) @(negedge clk);
    check("R9", req_out, 1'b1);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    check("R9", {req_out, db_oe, done}, 3'b001);
    @(negedge clk);
    check("R9", done, 1'b0);

    // R9: bus reset during receive hold window
    pulse_start(1'b1, 8'h00);
    ack_in = 1'b1;
    repeat (SYNC + 2) @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    check("R9", {req_out, db_oe, done}, 3'b001);
    ack_in = 1'b0;
    repeat (SYNC + 2) @(negedge clk);

    // R10: stray start during a receive does not drive the bus
    pulse_start(1'b1, 8'h00);
    repeat (2) @(negedge clk);
    pulse_start(1'b0, 8'hAA);
    repeat (SETUP + 2) @(negedge clk);
    check("R10", {req_out, db_oe}, 2'b10);
    db_in = {1'b1, 8'h00};
    ack_in = 1'b1;
    while (req_out) @(negedge clk);
    check("R10", rd_byte, 8'h00);
    ack_in = 1'b0;
    wait_done("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule